// File: doc/BRIEF.md
# Channel Request Router with Deferred Delivery

This block sits on the host-to-coprocessor side of a mailbox. A host write into a small address window carries a 32-bit message whose low four bits name a target channel. When that channel's endpoint can take the message, it is handed over in the same cycle. When the endpoint reports busy, the message is parked in an outbound queue, and the queue drains to its channels, in order, as they free up. Messages that name a channel which does not exist are discarded, and so are messages that arrive while the queue is full.

The block also gathers responses for the host. Each channel raises a response-available flag. The block pulls one word per cycle from the lowest-numbered channel that has a flag raised and pushes that word into the inbound mailbox, but only while the mailbox reports space. The queue's fill state is readable by the host at one status address.

Top module: `mbx_req_router`

## Requirements
- R1: A write is a host request only if its address lies between 0xA0 and 0xAC inclusive (for example 0xA0, 0xAC). Writes to any other address, such as 0x9C, 0xAD or 0xB0, deliver nothing and queue nothing.
- R2: Bits 3:0 of the written word select the channel. If the queue has space and that channel's busy input is low, `ch_wr` pulses for that channel in the same cycle as the write, and that channel's 32-bit slice of `ch_wdata` carries the whole word.
- R3: A request whose channel field is at or above `NCH` is discarded. No `ch_wr` pulse results, and the queue level does not change.
- R4: A request to a channel whose busy input is high is appended to the outbound queue. `ch_wr` never pulses for a channel while its busy input is high.
- R5: A read of address 0xB8 returns the queue status: bit 31 is full, bit 30 is empty, bits 7:0 hold the entry count, and all other bits are 0. The status reflects a write from the cycle after that write's clock edge. Reads of other addresses return 0.
- R6: A request that arrives while the queue holds `QDEPTH` entries is discarded. The level stays at `QDEPTH`, and the discarded word is never delivered.
- R7: When the channel named by the queue head has its busy input low, the head is delivered to that channel and removed from the queue. At most one entry leaves per cycle, and entries leave in arrival order.
- R8: Responses are collected from the lowest-numbered channel whose available input is high. One word moves per cycle: the `ch_rd` pulse for that channel and `ib_push` carrying that channel's `ch_rdata` slice occur in the same cycle.
- R9: While `ib_full` is high, no `ch_rd` pulse and no `ib_push` occur.
- R10: While reset is asserted, and up to the first clock edge after it is released, no strobe is issued on `ch_wr`, `ch_rd` or `ib_push`, whatever the available inputs show. After reset the queue is empty and the status reads 0x40000000.
- R11: If a host request targets the same channel that the queue head is being delivered to in that cycle, the request is queued rather than delivered, so that it reaches the channel one cycle after the older entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Host byte address within the block |
| req_wdata | input | 32 | Host write word |
| req_rdata | output | 32 | Host read word (combinational) |
| ch_wr | output | NCH | Per-channel message delivery strobe |
| ch_wdata | output | NCH*32 | Per-channel message word, slice i for channel i |
| ch_busy | input | NCH | Per-channel endpoint busy |
| ch_avail | input | NCH | Per-channel response available |
| ch_rd | output | NCH | Per-channel response pop strobe |
| ch_rdata | input | NCH*32 | Per-channel current response word |
| ib_push | output | 1 | Push strobe into the inbound mailbox |
| ib_data | output | 32 | Word pushed into the inbound mailbox |
| ib_full | input | 1 | Inbound mailbox has no space |

## Verification
Direct deliveries, response pops and inbound pushes are combinational. They are due in the same cycle as the write or the flag that causes them, so the bench logs `ch_wr`, `ch_rd` and `ib_push` at the falling clock edge, after inputs that change just past the rising edge have settled. The status word is registered and is due one cycle after the write's edge. Reads are therefore issued in a later cycle and sampled mid-cycle. Queue draining starts in the cycle in which busy falls and moves one entry per cycle, and the bench checks the cycle stamps of consecutive deliveries for exactly that spacing.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CH_FIELD_W = 4;
  localparam int unsigned ADDR_W     = 8;

  localparam logic [ADDR_W-1:0] REQ_WIN_LO = 8'hA0;
  localparam logic [ADDR_W-1:0] REQ_WIN_HI = 8'hAC;
  localparam logic [ADDR_W-1:0] QSTAT_ADDR = 8'hB8;

  localparam int unsigned STAT_FULL_BIT  = 31;
  localparam int unsigned STAT_EMPTY_BIT = 30;
  localparam int unsigned STAT_LEVEL_W   = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ROUTE_NONE   = 2'd0,
    ROUTE_DIRECT = 2'd1,
    ROUTE_DEFER  = 2'd2
  } route_e;
endpackage

// File: rtl/mbx_outq.sv
module mbx_outq #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 32,
  parameter logic [W-1:0] FILL = '0,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_d [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop, ptr_en;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign level   = cnt_q;
  assign head    = mem_q[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ptr_en  = do_push || do_pop;

  always_comb begin
    wr_d  = do_push ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    unique case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (do_pop)  mem_d[rd_q] = FILL;
    if (do_push) mem_d[wr_q] = push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= FILL;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end
endmodule

// File: rtl/mbx_req_decode.sv
module mbx_req_decode
  import mbx_pkg::*;
#(
  parameter int unsigned NCH = 9
) (
  input  logic              run,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  word_t             req_wdata,
  input  logic              q_full,
  input  logic [NCH-1:0]    ch_busy,
  input  logic [NCH-1:0]    drain_oh,
  output route_e            route,
  output logic [NCH-1:0]    tgt_oh
);
  logic                  in_win, ch_ok, blocked;
  logic [CH_FIELD_W-1:0] ch_sel;

  assign ch_sel = req_wdata[CH_FIELD_W-1:0];
  assign in_win = (req_addr >= REQ_WIN_LO) && (req_addr <= REQ_WIN_HI);
  assign ch_ok  = ({{(32-CH_FIELD_W){1'b0}}, ch_sel} < NCH);

  for (genvar g = 0; g < NCH; g++) begin : g_tgt
    assign tgt_oh[g] = (ch_sel == CH_FIELD_W'(g));
  end

  assign blocked = |(tgt_oh & (ch_busy | drain_oh));

  always_comb begin
    route = ROUTE_NONE;
    if (run && req_valid && req_write && in_win && ch_ok && !q_full) begin
      route = blocked ? ROUTE_DEFER : ROUTE_DIRECT;
    end
  end
endmodule

// File: rtl/mbx_resp_collect.sv
module mbx_resp_collect
  import mbx_pkg::*;
#(
  parameter int unsigned NCH = 9
) (
  input  logic                  run,
  input  logic                  ib_full,
  input  logic [NCH-1:0]        ch_avail,
  input  logic [NCH*WORD_W-1:0] ch_rdata,
  output logic [NCH-1:0]        ch_rd,
  output logic                  ib_push,
  output word_t                 ib_data
);
  logic [NCH-1:0] pick;
  logic           found, go;
  word_t          sel_word;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_avail[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NCH; i++) begin
      sel_word = sel_word | (ch_rdata[i*WORD_W +: WORD_W] & {WORD_W{pick[i]}});
    end
  end

  assign go      = run && !ib_full && found;
  assign ch_rd   = go ? pick : '0;
  assign ib_push = go;
  assign ib_data = sel_word;
endmodule

// File: rtl/mbx_req_router.sv
module mbx_req_router
  import mbx_pkg::*;
#(
  parameter int unsigned NCH          = 9,
  parameter int unsigned QDEPTH       = 4,
  parameter logic [31:0] INVALID_WORD = 32'h0000_0001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [7:0]            req_addr,
  input  logic [31:0]           req_wdata,
  output logic [31:0]           req_rdata,
  output logic [NCH-1:0]        ch_wr,
  output logic [NCH*32-1:0]     ch_wdata,
  input  logic [NCH-1:0]        ch_busy,
  input  logic [NCH-1:0]        ch_avail,
  output logic [NCH-1:0]        ch_rd,
  input  logic [NCH*32-1:0]     ch_rdata,
  output logic                  ib_push,
  output logic [31:0]           ib_data,
  input  logic                  ib_full
);
  localparam int unsigned QCW = $clog2(QDEPTH + 1);

  logic           run_q, run_d;
  route_e         route;
  logic [NCH-1:0] tgt_oh, head_oh, drain_oh;
  logic           q_push, q_pop, q_full, q_empty, drain_go;
  logic [QCW-1:0] q_level;
  word_t          q_head, qstat;
  logic [CH_FIELD_W-1:0] head_ch;

  // collection and delivery held off until one edge after reset release
  assign run_d = 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign head_ch = q_head[CH_FIELD_W-1:0];
  for (genvar g = 0; g < NCH; g++) begin : g_head
    assign head_oh[g] = (head_ch == CH_FIELD_W'(g));
  end

  assign drain_go = run_q && !q_empty && !(|(head_oh & ch_busy));
  assign drain_oh = drain_go ? head_oh : '0;
  assign q_pop    = drain_go;
  assign q_push   = (route == ROUTE_DEFER);

  mbx_req_decode #(.NCH(NCH)) u_dec (
    .run       (run_q),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .q_full    (q_full),
    .ch_busy   (ch_busy),
    .drain_oh  (drain_oh),
    .route     (route),
    .tgt_oh    (tgt_oh)
  );

  mbx_outq #(.DEPTH(QDEPTH), .W(WORD_W), .FILL(INVALID_WORD)) u_outq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (req_wdata),
    .pop       (q_pop),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty),
    .level     (q_level)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_deliver
    logic direct_hit;
    assign direct_hit = (route == ROUTE_DIRECT) && tgt_oh[g];
    assign ch_wr[g]   = direct_hit || drain_oh[g];
    assign ch_wdata[g*WORD_W +: WORD_W] = direct_hit ? req_wdata : q_head;
  end

  mbx_resp_collect #(.NCH(NCH)) u_rsp (
    .run      (run_q),
    .ib_full  (ib_full),
    .ch_avail (ch_avail),
    .ch_rdata (ch_rdata),
    .ch_rd    (ch_rd),
    .ib_push  (ib_push),
    .ib_data  (ib_data)
  );

  always_comb begin
    qstat = '0;
    qstat[STAT_FULL_BIT]  = q_full;
    qstat[STAT_EMPTY_BIT] = q_empty;
    qstat[STAT_LEVEL_W-1:0] = STAT_LEVEL_W'(q_level);
  end

  assign req_rdata = (req_valid && !req_write && (req_addr == QSTAT_ADDR)) ? qstat : '0;
endmodule

// File: rtl/mbx_req_router_chk.sv
module mbx_req_router_chk
  import mbx_pkg::*;
#(
  parameter int unsigned NCH    = 9,
  parameter int unsigned QDEPTH = 4,
  localparam int unsigned QCW   = $clog2(QDEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_write,
  input logic [7:0]     req_addr,
  input logic [31:0]    req_wdata,
  input logic [NCH-1:0] ch_wr,
  input logic [NCH-1:0] ch_busy,
  input logic [NCH-1:0] ch_avail,
  input logic [NCH-1:0] ch_rd,
  input logic           ib_push,
  input logic           ib_full,
  input logic           q_full,
  input logic [QCW-1:0] q_level
);
  logic bad_ch_req;
  assign bad_ch_req = req_valid && req_write && (req_addr >= REQ_WIN_LO) &&
                      (req_addr <= REQ_WIN_HI) &&
                      ({28'd0, req_wdata[3:0]} >= NCH);

  p_no_wr_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr & ch_busy) == '0);

  p_bad_ch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ch_req |=> (q_level <= $past(q_level)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= QCW'(QDEPTH));

  p_full_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && (ch_wr == '0)) |=> q_full);

  p_rd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rd));

  p_rd_avail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd & ~ch_avail) == '0);

  p_push_pairs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ib_push == (ch_rd != '0));

  p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ib_full |-> !ib_push);

  p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ch_rd == '0 && ch_wr == '0));
endmodule

bind mbx_req_router mbx_req_router_chk #(.NCH(NCH), .QDEPTH(QDEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .ch_wr     (ch_wr),
  .ch_busy   (ch_busy),
  .ch_avail  (ch_avail),
  .ch_rd     (ch_rd),
  .ib_push   (ib_push),
  .ib_full   (ib_full),
  .q_full    (q_full),
  .q_level   (q_level)
);

// File: tb/mbx_req_router_tb.sv
`timescale 1ns/1ps
module mbx_req_router_tb;
  localparam int NCH = 9;
  localparam int QD  = 4;
  localparam int W   = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_write;
  logic [7:0]        req_addr;
  logic [31:0]       req_wdata, req_rdata;
  logic [NCH-1:0]    ch_wr, ch_busy, ch_avail, ch_rd;
  logic [NCH*W-1:0]  ch_wdata, ch_rdata;
  logic              ib_push, ib_full;
  logic [31:0]       ib_data;

  mbx_req_router #(.NCH(NCH), .QDEPTH(QD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .ch_wr(ch_wr), .ch_wdata(ch_wdata), .ch_busy(ch_busy), .ch_avail(ch_avail),
    .ch_rd(ch_rd), .ch_rdata(ch_rdata), .ib_push(ib_push), .ib_data(ib_data),
    .ib_full(ib_full)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // endpoint response model
  int rsp_cnt [NCH];
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_avail[i] = (rsp_cnt[i] > 0);
      ch_rdata[i*W +: W] = {8'(i), 8'hC0, 16'(rsp_cnt[i])};
    end
  end
  always @(posedge clk) begin
    for (int i = 0; i < NCH; i++) if (ch_rd[i]) rsp_cnt[i] <= rsp_cnt[i] - 1;
  end

  // cycle counter and strobe logger (sampled mid-cycle)
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          wr_n = 0, rsp_n = 0;
  int          wr_ch  [256];
  int          wr_cyc [256];
  logic [31:0] wr_dat [256];
  logic [31:0] rsp_dat[256];
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (ch_wr[i] && wr_n < 256) begin
        wr_ch[wr_n]  = i;
        wr_cyc[wr_n] = cyc;
        wr_dat[wr_n] = ch_wdata[i*W +: W];
        wr_n++;
      end
    end
    if (ib_push && rsp_n < 256) begin
      rsp_dat[rsp_n] = ib_data;
      rsp_n++;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic host_write(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #2;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic host_read(logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #5 d = req_rdata;
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] s;
    int base;
    rsp_cnt[0] <= 1;
    #5;
    chk("R10", "ch_rd in reset", 32'(ch_rd), 32'h0);
    chk("R10", "ib_push in reset", 32'(ib_push), 32'h0);
    @(posedge clk); #2;
    base = rsp_n;
    rst_n = 1'b1;
    #5;
    chk("R10", "ch_rd first cycle out of reset", 32'(ch_rd), 32'h0);
    idle(3);
    chk("R10", "held response collected after run", 32'(rsp_n - base), 32'd1);
    chk("R10", "held response word", rsp_dat[base], 32'h00C0_0001);
    host_read(8'hB8, s);
    chk("R10", "status after reset", s, 32'h4000_0000);
  endtask

  task automatic t_direct;
    int base = wr_n;
    logic [31:0] s;
    host_write(8'hA0, 32'hDEAD_BE03);
    chk("R2", "direct deliveries", 32'(wr_n - base), 32'd1);
    chk("R2", "direct channel", 32'(wr_ch[base]), 32'd3);
    chk("R2", "direct word", wr_dat[base], 32'hDEAD_BE03);
    host_read(8'hB8, s);
    chk("R2", "queue still empty", s, 32'h4000_0000);
  endtask

  task automatic t_window;
    int base = wr_n;
    logic [31:0] s;
    host_write(8'hAC, 32'h0000_AC04);
    chk("R1", "top of window delivered", 32'(wr_n - base), 32'd1);
    chk("R1", "top of window channel", 32'(wr_ch[base]), 32'd4);
    host_write(8'hB0, 32'h0000_B004);
    host_write(8'h9C, 32'h0000_9C04);
    host_write(8'hAD, 32'h0000_AD04);
    chk("R1", "outside window delivers nothing", 32'(wr_n - base), 32'd1);
    host_read(8'hB8, s);
    chk("R1", "outside window queues nothing", s, 32'h4000_0000);
    host_read(8'hA0, s);
    chk("R5", "non-status read", s, 32'h0);
  endtask

  task automatic t_badch;
    int base = wr_n;
    logic [31:0] s;
    ch_busy = '1;
    host_write(8'hA4, 32'h1111_000A);
    host_write(8'hA8, 32'h2222_000F);
    ch_busy = '0;
    host_write(8'hA0, 32'h3333_0009);
    chk("R3", "bad channel deliveries", 32'(wr_n - base), 32'd0);
    host_read(8'hB8, s);
    chk("R3", "bad channel not queued", s, 32'h4000_0000);
  endtask

  task automatic t_defer;
    int base = wr_n;
    int rel;
    logic [31:0] s;
    ch_busy[2] = 1'b1;
    host_write(8'hA0, 32'h1111_0002);
    host_write(8'hA4, 32'h2222_0002);
    host_write(8'hA0, 32'h3333_0003);
    chk("R4", "only ch3 delivered while ch2 busy", 32'(wr_n - base), 32'd1);
    chk("R4", "delivered channel", 32'(wr_ch[base]), 32'd3);
    host_read(8'hB8, s);
    chk("R5", "status with two queued", s, 32'h0000_0002);
    rel = wr_n;
    ch_busy[2] = 1'b0;
    idle(4);
    chk("R7", "drained count", 32'(wr_n - rel), 32'd2);
    chk("R7", "first drained channel", 32'(wr_ch[rel]), 32'd2);
    chk("R7", "first drained word", wr_dat[rel], 32'h1111_0002);
    chk("R7", "second drained word", wr_dat[rel+1], 32'h2222_0002);
    chk("R7", "one entry per cycle", 32'(wr_cyc[rel+1] - wr_cyc[rel]), 32'd1);
    host_read(8'hB8, s);
    chk("R5", "status after drain", s, 32'h4000_0000);
  endtask

  task automatic t_full;
    int rel;
    logic [31:0] s;
    ch_busy[1] = 1'b1;
    for (int k = 0; k <= QD; k++) host_write(8'hA0, {16'(k), 16'h0001});
    host_read(8'hB8, s);
    chk("R6", "status when full", s, 32'h8000_0000 | QD);
    rel = wr_n;
    ch_busy[1] = 1'b0;
    idle(QD + 3);
    chk("R6", "only queued entries delivered", 32'(wr_n - rel), 32'(QD));
    for (int k = 0; k < QD; k++) chk("R7", "full drain order", wr_dat[rel+k], {16'(k), 16'h0001});
    host_read(8'hB8, s);
    chk("R6", "empty after full drain", s, 32'h4000_0000);
  endtask

  task automatic t_conflict;
    int rel;
    logic [31:0] s;
    ch_busy[2] = 1'b1;
    host_write(8'hA0, 32'hAAAA_0002);
    rel = wr_n;
    @(posedge clk); #2;
    ch_busy[2] = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hA0; req_wdata = 32'hBBBB_0002;
    @(posedge clk); #2;
    req_valid = 1'b0; req_write = 1'b0;
    idle(3);
    chk("R11", "both delivered", 32'(wr_n - rel), 32'd2);
    chk("R11", "older first", wr_dat[rel], 32'hAAAA_0002);
    chk("R11", "newer second", wr_dat[rel+1], 32'hBBBB_0002);
    chk("R11", "newer one cycle later", 32'(wr_cyc[rel+1] - wr_cyc[rel]), 32'd1);
    host_read(8'hB8, s);
    chk("R11", "queue empty", s, 32'h4000_0000);
  endtask

  task automatic t_resp;
    int base = rsp_n;
    @(posedge clk); #2;
    rsp_cnt[5] <= 2;
    rsp_cnt[1] <= 1;
    idle(5);
    chk("R8", "response count", 32'(rsp_n - base), 32'd3);
    chk("R8", "lowest channel first", rsp_dat[base], 32'h01C0_0001);
    chk("R8", "then ch5 word a", rsp_dat[base+1], 32'h05C0_0002);
    chk("R8", "then ch5 word b", rsp_dat[base+2], 32'h05C0_0001);
  endtask

  task automatic t_ibfull;
    int base = rsp_n;
    @(posedge clk); #2;
    ib_full = 1'b1;
    rsp_cnt[7] <= 2;
    idle(5);
    chk("R9", "no pushes while full", 32'(rsp_n - base), 32'd0);
    chk("R9", "endpoint not popped", 32'(rsp_cnt[7]), 32'd2);
    ib_full = 1'b0;
    idle(4);
    chk("R9", "pushes resume", 32'(rsp_n - base), 32'd2);
    chk("R9", "first resumed word", rsp_dat[base], 32'h07C0_0002);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    ch_busy = '0; ib_full = 1'b0;
    for (int i = 0; i < NCH; i++) rsp_cnt[i] <= 0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_direct();
    t_window();
    t_badch();
    t_defer();
    t_full();
    t_conflict();
    t_resp();
    t_ibfull();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule